// File: doc/BRIEF.md
# Eight-Channel Match Timer with Shared Counters

The block holds eight timer channels, numbered 4 to 11. Each channel has its own counter, a match value and a control word. The control word picks which of five tick-enable inputs advances the counter. It also sets what a match does: it can clear the counter, and it can keep the channel armed for further matches or make it fire once only. When the channel's own-counter bit is clear, the channel compares its match value against a counter owned by a group leader instead of its own counter. Channels 9 and 11 can freeze their neighbour's count into a snapshot register when software reads their own counter.

Software reaches the block through a simple word-wide register port. A write applies at the clock edge on which `wr_en` is high. Read data is combinational from `addr` while `rd_en` is high. Every match sets the status bit that carries the channel's number. A single interrupt output stays high while any of those status bits is set. The tick inputs are single-cycle enables produced elsewhere, so no clock division happens inside the block. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `mchan_timer`

## Requirements
- R1: After reset release, every counter, match value, control word, the status register at 0x14 and the snapshot register at 0x20 read as zero, and `irq` is low.
- R2: Channel n (4..11) has its counter at 0x40+4*(n-4), its match value at 0x80+4*(n-4) and its control word at 0xC0+4*(n-4); a counter write loads the written value, and a match write stores the value and arms the channel.
- R3: Control bits [2:0] pick the tick source: 1 selects `tick_en[0]`, 2 `tick_en[1]`, 3 `tick_en[2]`, 4 `tick_en[3]`, 5 `tick_en[4]`. A running counter advances by one on each cycle its selected enable is high. Codes 0, 6 and 7 stop it, and a stopped counter holds and reads back its value.
- R4: On channels 8 to 11, control bit 8 set stops the counter whatever the source code is.
- R5: Channels 4 to 7 keep only control bits [7:0]; channels 8 to 11 keep bits [9:0]; the rest read as zero.
- R6: An armed channel matches on the cycle its selected counter steps to a value equal to its match value. The match sets status bit n of the register at 0x14 on the following edge.
- R7: On a match with control bit 3 set, the channel's own counter is loaded with zero instead of stepping.
- R8: With control bit 6 clear a channel disarms after its first match; with bit 6 set it stays armed and matches again.
- R9: With control bit 7 clear, channels 4 to 7 compare against channel 4's counter, 8 and 9 against channel 8's, and 10 and 11 against channel 10's. The own counter of a non-leader channel then stays still; the leaders 4, 8 and 10 always count on their own counter.
- R10: A read of channel 9's counter with its control bit 9 set copies channel 8's count into the snapshot register. The same holds for channel 11 with channel 10. With bit 9 clear the snapshot is unchanged.
- R11: Writing ones to bits 4..11 at 0x14 clears those status bits; a match in the same cycle wins. `irq` is high exactly while any status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 5 | Single-cycle tick enables: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers snapshot capture) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq | output | 1 | Combined match interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together. They also assume that each tick enable is a one-cycle pulse, sampled on the same edge as the register port. The bench drives the port only through tasks that raise a single strobe for exactly one cycle. It changes tick enables only while no register access is in progress, so a counter write never races a tick on the channel it targets. Random tick patterns are drawn from a seeded generator. The expected counts come from how often the selected enable bit was high.

// File: rtl/mctm_pkg.sv
package mctm_pkg;
  localparam int NUM_CH   = 8;   // channels 4..11
  localparam int FIRST_CH = 4;   // number of the first channel
  localparam int NUM_SRC  = 5;   // tick-enable inputs
  localparam int CTL_W    = 10;  // widest control word

  localparam logic [7:0] CNT_BASE = 8'h40;
  localparam logic [7:0] MAT_BASE = 8'h80;
  localparam logic [7:0] CTL_BASE = 8'hC0;
  localparam logic [7:0] STAT_OFS = 8'h14;
  localparam logic [7:0] SNAP_OFS = 8'h20;

  // control-word bit positions
  localparam int B_CLR  = 3;
  localparam int B_PER  = 6;
  localparam int B_OWN  = 7;
  localparam int B_HALT = 8;
  localparam int B_SNAP = 9;

  // snapshot pairs (internal indices: channel minus FIRST_CH)
  localparam int SNAP_RD_A  = 5;
  localparam int SNAP_SRC_A = 4;
  localparam int SNAP_RD_B  = 7;
  localparam int SNAP_SRC_B = 6;

  // group leader whose counter a channel shares
  function automatic int leader_of(int idx);
    if (idx < 4)      return 0;
    else if (idx < 6) return 4;
    else              return 6;
  endfunction
endpackage

// File: rtl/mctm_rst_sync.sv
module mctm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mctm_channel.sv
module mctm_channel
  import mctm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit IS_LEAD = 1'b0,
  parameter bit WIDE    = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_in,
  input  logic               ctl_we,
  input  logic               mat_we,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   wdata,
  input  logic               lead_step,
  input  logic [CNT_W-1:0]   lead_cand,
  output logic               step_o,
  output logic [CNT_W-1:0]   cand_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   mat_o,
  output logic [CTL_W-1:0]   ctl_o,
  output logic               hit_o
);
  localparam logic [CTL_W-1:0] KEEP = WIDE ? CTL_W'(10'h3FF) : CTL_W'(10'h0FF);

  logic [CNT_W-1:0] cnt_q, cnt_d, mat_q, mat_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             armed_q, armed_d;
  logic             cnt_en, mat_en, ctl_en, armed_en;
  logic [2:0]       src;
  logic             halted, uses_own, runs, tick_sel;
  logic             sel_step;
  logic [CNT_W-1:0] sel_cand;

  assign src      = ctl_q[2:0];
  assign halted   = WIDE && ctl_q[B_HALT];
  assign uses_own = IS_LEAD || ctl_q[B_OWN];
  assign runs     = uses_own && !halted && (src != 3'd0) && (src <= 3'(NUM_SRC));

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (src == 3'(k + 1)) tick_sel = tick_in[k];
    end
  end

  assign step_o   = runs && tick_sel && !cnt_we;
  assign cand_o   = cnt_q + CNT_W'(1);
  assign sel_step = ctl_q[B_OWN] || IS_LEAD ? step_o : lead_step;
  assign sel_cand = ctl_q[B_OWN] || IS_LEAD ? cand_o : lead_cand;
  assign hit_o    = armed_q && sel_step && (sel_cand == mat_q);

  // next-state
  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)                     cnt_d = wdata;
    else if (hit_o && ctl_q[B_CLR]) cnt_d = '0;
    else if (step_o)                cnt_d = cand_o;
    cnt_en = cnt_we || (hit_o && ctl_q[B_CLR]) || step_o;

    mat_d  = wdata;
    mat_en = mat_we;

    ctl_d  = wdata[CTL_W-1:0] & KEEP;
    ctl_en = ctl_we;

    armed_d  = mat_we;
    armed_en = mat_we || (hit_o && !ctl_q[B_PER]);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mat_q   <= '0;
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (mat_en)   mat_q   <= mat_d;
      if (ctl_en)   ctl_q   <= ctl_d;
      if (armed_en) armed_q <= armed_d;
    end
  end

  assign cnt_o = cnt_q;
  assign mat_o = mat_q;
  assign ctl_o = ctl_q;

  // R3: a counter whose source is stopped and that is neither written nor cleared holds
  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[2:0] == 3'd0 && !cnt_we && !(hit_o && ctl_q[B_CLR])) |=> cnt_q == $past(cnt_q));

  // R4: halt bit on wide channels freezes the counter
  a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE && ctl_q[B_HALT] && !cnt_we && !(hit_o && ctl_q[B_CLR])) |=> cnt_q == $past(cnt_q));

  // R7: clear-on-match loads zero
  a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ctl_q[B_CLR] && !cnt_we) |=> cnt_q == '0);

  // R8: one-shot channel cannot hit again until re-armed
  a_r8_oneshot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !ctl_q[B_PER] && !mat_we) |=> !hit_o);
endmodule

// File: rtl/mctm_regs.sv
module mctm_regs
  import mctm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_CH-1:0]             hit_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cnt_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] mat_i,
  input  logic [NUM_CH-1:0][CTL_W-1:0]  ctl_i,
  output logic [NUM_CH-1:0]             cnt_we,
  output logic [NUM_CH-1:0]             mat_we,
  output logic [NUM_CH-1:0]             ctl_we,
  output logic [DATA_W-1:0]             rdata,
  output logic                          irq
);
  logic [NUM_CH-1:0] sel_cnt, sel_mat, sel_ctl;
  logic              sel_stat, sel_snap;
  logic [NUM_CH-1:0] st_q, st_d, st_clr;
  logic              st_en;
  logic [DATA_W-1:0] snap_q, snap_d;
  logic              snap_en;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign sel_cnt[i] = addr == ADDR_W'(CNT_BASE + 8'(4 * i));
    assign sel_mat[i] = addr == ADDR_W'(MAT_BASE + 8'(4 * i));
    assign sel_ctl[i] = addr == ADDR_W'(CTL_BASE + 8'(4 * i));
  end
  assign sel_stat = addr == ADDR_W'(STAT_OFS);
  assign sel_snap = addr == ADDR_W'(SNAP_OFS);

  assign cnt_we = {NUM_CH{wr_en}} & sel_cnt;
  assign mat_we = {NUM_CH{wr_en}} & sel_mat;
  assign ctl_we = {NUM_CH{wr_en}} & sel_ctl;

  // next-state for status and snapshot
  always_comb begin
    st_clr = (wr_en && sel_stat) ? wdata[FIRST_CH +: NUM_CH] : '0;
    st_d   = (st_q & ~st_clr) | hit_i;
    st_en  = (|st_clr) || (|hit_i);

    snap_en = 1'b0;
    snap_d  = snap_q;
    if (rd_en && sel_cnt[SNAP_RD_A] && ctl_i[SNAP_RD_A][B_SNAP]) begin
      snap_en = 1'b1;
      snap_d  = cnt_i[SNAP_SRC_A];
    end else if (rd_en && sel_cnt[SNAP_RD_B] && ctl_i[SNAP_RD_B][B_SNAP]) begin
      snap_en = 1'b1;
      snap_d  = cnt_i[SNAP_SRC_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      snap_q <= '0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (snap_en) snap_q <= snap_d;
    end
  end

  assign irq = |st_q;

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_cnt[i]) rdata = cnt_i[i];
      if (sel_mat[i]) rdata = mat_i[i];
      if (sel_ctl[i]) rdata = DATA_W'(ctl_i[i]);
    end
    if (sel_stat) rdata = DATA_W'(st_q) << FIRST_CH;
    if (sel_snap) rdata = snap_q;
  end

  // R6: every match leaves its status bit set
  a_r6_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((st_q & $past(hit_i)) == $past(hit_i)));

  // R11: clearing every set bit with no new match drops the interrupt
  a_r11_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_stat && ((st_q & ~wdata[FIRST_CH +: NUM_CH]) == '0) && hit_i == '0) |=> !irq);

  // R10: snapshot of channel 8 taken on a channel-9 counter read
  a_r10_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_cnt[SNAP_RD_A] && ctl_i[SNAP_RD_A][B_SNAP]) |=> snap_q == $past(cnt_i[SNAP_SRC_A]));

  // R10: no counter read of a snapshot channel, no change
  a_r10_snap_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (sel_cnt[SNAP_RD_A] || sel_cnt[SNAP_RD_B])) |=> $stable(snap_q));
endmodule

// File: rtl/mchan_timer.sv
module mchan_timer
  import mctm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_en,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  logic                          rst_int_n;
  logic [NUM_CH-1:0]             step, hit;
  logic [NUM_CH-1:0][DATA_W-1:0] cand, cnt, mat;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctl;
  logic [NUM_CH-1:0]             cnt_we, mat_we, ctl_we;

  mctm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int LEAD = leader_of(i);
    mctm_channel #(
      .CNT_W   (DATA_W),
      .IS_LEAD (LEAD == i),
      .WIDE    (i >= NUM_CH / 2)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .tick_in   (tick_en),
      .ctl_we    (ctl_we[i]),
      .mat_we    (mat_we[i]),
      .cnt_we    (cnt_we[i]),
      .wdata     (wdata),
      .lead_step (step[LEAD]),
      .lead_cand (cand[LEAD]),
      .step_o    (step[i]),
      .cand_o    (cand[i]),
      .cnt_o     (cnt[i]),
      .mat_o     (mat[i]),
      .ctl_o     (ctl[i]),
      .hit_o     (hit[i])
    );
  end

  mctm_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .hit_i  (hit),
    .cnt_i  (cnt),
    .mat_i  (mat),
    .ctl_i  (ctl),
    .cnt_we (cnt_we),
    .mat_we (mat_we),
    .ctl_we (ctl_we),
    .rdata  (rdata),
    .irq    (irq)
  );

  // port usage rule the checks rely on
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_en && rd_en));
endmodule

// File: tb/mchan_timer_test.sv
module mchan_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  tick_en;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mchan_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // expected-value helpers from the requirements
  function automatic logic [7:0] cnt_a(int ch); return 8'h40 + 8'(4 * (ch - 4)); endfunction
  function automatic logic [7:0] mat_a(int ch); return 8'h80 + 8'(4 * (ch - 4)); endfunction
  function automatic logic [7:0] ctl_a(int ch); return 8'hC0 + 8'(4 * (ch - 4)); endfunction
  function automatic logic [31:0] keep_of(int ch); return (ch >= 8) ? 32'h3FF : 32'hFF; endfunction
  function automatic logic [31:0] stat_of(int ch); return 32'h1 << ch; endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(int code, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = 5'b0;
      tick_en[code - 1] = 1'b1;
      @(negedge clk);
      tick_en = 5'b0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    int          seed;
    rst_n = 1'b0; tick_en = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    seed = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(cnt_a(4), v);  check("R1 counter ch4", v, 0);
    rd(mat_a(11), v); check("R1 match ch11", v, 0);
    rd(ctl_a(9), v);  check("R1 control ch9", v, 0);
    rd(8'h14, v);     check("R1 status", v, 0);
    rd(8'h20, v);     check("R1 snapshot", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 address map and loads
    wr(cnt_a(5), 32'h0000_1234); rd(cnt_a(5), v); check("R2 counter load ch5", v, 32'h1234);
    wr(mat_a(6), 32'h0000_00AB); rd(mat_a(6), v); check("R2 match store ch6", v, 32'hAB);

    // R3 source select, ignored sources, stopped codes
    wr(ctl_a(4), 32'h81);
    pulse(1, 5); rd(cnt_a(4), v); check("R3 src1 counts", v, 5);
    pulse(2, 3); rd(cnt_a(4), v); check("R3 other source ignored", v, 5);
    wr(ctl_a(4), 32'h86);
    for (int c = 1; c <= 5; c++) pulse(c, 1);
    rd(cnt_a(4), v); check("R3 code 6 holds", v, 5);

    // R3 random tick patterns for every source code on channel 7
    for (int code = 1; code <= 5; code++) begin
      wr(ctl_a(7), 32'h80 | code);
      wr(cnt_a(7), 0);
      exp = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        tick_en = 5'($urandom);
        if (tick_en[code - 1]) exp++;
      end
      @(negedge clk);
      tick_en = '0;
      rd(cnt_a(7), v); check($sformatf("R3 random code %0d", code), v, exp);
    end
    wr(ctl_a(7), 0);

    // R5 control widths
    wr(ctl_a(5), 32'hFFFF_FFFF); rd(ctl_a(5), v); check("R5 narrow control", v, keep_of(5));
    wr(ctl_a(9), 32'hFFFF_FFFF); rd(ctl_a(9), v); check("R5 wide control", v, keep_of(9));
    wr(ctl_a(5), 0); wr(ctl_a(9), 0);

    // R4 halt bit
    wr(ctl_a(8), 32'h181); wr(cnt_a(8), 32'h10);
    pulse(1, 3); rd(cnt_a(8), v); check("R4 halted ch8", v, 32'h10);
    wr(ctl_a(8), 32'h081);
    pulse(1, 2); rd(cnt_a(8), v); check("R4 released ch8", v, 32'h12);

    // R6 match sets status, R11 irq and clear
    wr(ctl_a(10), 32'h81); wr(cnt_a(10), 0); wr(mat_a(10), 3);
    pulse(1, 2); rd(8'h14, v); check("R6 no status before match", v, 0);
    pulse(1, 1); rd(8'h14, v); check("R6 status on match", v, stat_of(10));
    check("R11 irq set", {31'b0, irq}, 1);
    wr(8'h14, stat_of(4)); rd(8'h14, v); check("R11 other bit write keeps", v, stat_of(10));
    wr(8'h14, stat_of(10)); rd(8'h14, v); check("R11 status cleared", v, 0);
    check("R11 irq cleared", {31'b0, irq}, 0);

    // R8 one-shot
    wr(cnt_a(10), 0); pulse(1, 3);
    rd(8'h14, v); check("R8 one-shot silent", v, 0);

    // R7 clear-on-match and R8 periodic
    wr(ctl_a(10), 32'hC9); wr(cnt_a(10), 0); wr(mat_a(10), 2);
    pulse(1, 2); rd(cnt_a(10), v); check("R7 counter cleared", v, 0);
    rd(8'h14, v); check("R8 periodic first", v, stat_of(10));
    wr(8'h14, 32'hFF0);
    pulse(1, 2); rd(8'h14, v); check("R8 periodic again", v, stat_of(10));
    wr(8'h14, 32'hFF0);
    wr(ctl_a(10), 0);

    // R9 shared counter
    wr(ctl_a(4), 32'h01); wr(cnt_a(4), 0);
    wr(ctl_a(6), 32'h01); wr(cnt_a(6), 32'h77); wr(mat_a(6), 4);
    pulse(1, 4);
    rd(8'h14, v); check("R9 ch6 on ch4 counter", v, stat_of(6));
    rd(cnt_a(6), v); check("R9 own counter still", v, 32'h77);
    wr(8'h14, 32'hFF0); wr(ctl_a(4), 0); wr(ctl_a(6), 0);

    // R10 snapshot
    wr(ctl_a(8), 0); wr(cnt_a(8), 32'h50);
    wr(ctl_a(9), 32'h280);
    rd(cnt_a(9), v); rd(8'h20, v); check("R10 snapshot ch8", v, 32'h50);
    wr(cnt_a(10), 32'h99); wr(ctl_a(11), 32'h080);
    rd(cnt_a(11), v); rd(8'h20, v); check("R10 bit9 clear no capture", v, 32'h50);
    wr(ctl_a(11), 32'h280);
    rd(cnt_a(11), v); rd(8'h20, v); check("R10 snapshot ch10", v, 32'h99);

    finish_run();
  end
endmodule